// File: doc/BRIEF.md
# Conditional Token Split Node

This block steers tokens in a dataflow pipeline. It has a control channel, a data channel and `NUM_OUT` output channels, each with valid/ready handshaking. One control token and one data token are joined into a single operation. The data token then leaves on exactly the output that the control value names, and nothing appears on any other output. Unlike a demultiplexer, an unselected output sees no activity at all. Backpressure on an output only matters when that output is the one selected.

Each output owns a one-token register slot, so a token leaves the node one cycle after it is accepted. A control value that names no existing output is treated as an error. The node consumes both input tokens, discards the data and raises a one-cycle error pulse. The node is meant to be placed between producers and consumers in a token network. Split trees wider than one node are formed outside it.

Top module: `token_split_node`

## Requirements
- R1: While reset is asserted and directly after it, every `z_valid` bit is 0, `err_pulse` is 0 and `c_ready` is 0.
- R2: `c_ready` and `a_ready` are 0 in any cycle in which `c_valid` and `a_valid` are not both 1. A lone control token or a lone data token is never consumed.
- R3: A joined operation with control value i < `NUM_OUT` makes bit i of `z_valid` high in the cycle after acceptance. The output word at bits `[i*DATA_W +: DATA_W]` of `z_data` then equals the accepted data token.
- R4: An accepted operation puts a token on at most one output. An output that was not selected receives no new token.
- R5: The control and data tokens are consumed together: `c_ready` equals `a_ready` in every cycle.
- R6: If the selected output holds a token that its consumer is not taking (`z_valid[i]`=1, `z_ready[i]`=0), neither input is accepted.
- R7: A stalled output that is not selected does not delay an operation aimed at a free output.
- R8: A control value of `NUM_OUT` or more consumes both inputs, produces no output token and raises `err_pulse` for exactly the following cycle.
- R9: An output token stays valid with stable data until its consumer accepts it. Each output delivers its tokens in the order they were accepted.
- R10: With the selected output ready, the node accepts one operation in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| c_valid | input | 1 | Control token present |
| c_ready | output | 1 | Control token consumed this cycle |
| c_sel | input | CTRL_W | Control value: index of the output |
| a_valid | input | 1 | Data token present |
| a_ready | output | 1 | Data token consumed this cycle |
| a_data | input | DATA_W | Data token payload |
| z_valid | output | NUM_OUT | Per-output token present |
| z_ready | input | NUM_OUT | Per-output consumer accepts |
| z_data | output | NUM_OUT*DATA_W | Output payloads, output i in bits [i*DATA_W +: DATA_W] |
| err_pulse | output | 1 | One-cycle flag after an out-of-range control value was consumed |

## Verification
The assertions check the following on every cycle: the joint consumption of both inputs, the rule that nothing is consumed without both tokens, and that a stalled selected output blocks acceptance. They also check that a token lands on the named output the cycle after acceptance with the accepted payload, that no unselected output gains a token, the error pulse timing, and that an output is held while its consumer stalls. Only the bench scenarios can show per-output ordering across long streams, a stalled neighbour not costing any cycles, and full one-per-cycle throughput. Those properties come from comparing each output against a queue of expected tokens and from counting wait cycles.

// File: rtl/tsplit_pkg.sv
package tsplit_pkg;

  // occupancy of a single output slot
  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_state_e;

endpackage

// File: rtl/tsplit_rst_sync.sv
module tsplit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_core_n = chain_q[STAGES-1];

endmodule

// File: rtl/tsplit_steer.sv
module tsplit_steer #(
  parameter int NUM_OUT = 4,
  parameter int CTRL_W  = 3
) (
  input  logic               run,
  input  logic               c_valid,
  input  logic               a_valid,
  input  logic [CTRL_W-1:0]  c_sel,
  input  logic [NUM_OUT-1:0] slot_ready,
  output logic               fire,
  output logic               bad_sel,
  output logic [NUM_OUT-1:0] load
);

  localparam logic [CTRL_W:0] SEL_LIMIT = (CTRL_W+1)'(NUM_OUT);

  logic [NUM_OUT-1:0] sel_hot;
  logic               in_range;
  logic               joined;
  logic               target_ready;

  // one-hot decode of the control value
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_dec
    assign sel_hot[i] = (c_sel == CTRL_W'(i));
  end

  always_comb begin
    in_range     = ({1'b0, c_sel} < SEL_LIMIT);
    joined       = run && c_valid && a_valid;
    target_ready = |(sel_hot & slot_ready);
    // out-of-range values drain at once; legal ones wait for their slot
    fire         = joined && (!in_range || target_ready);
    bad_sel      = fire && !in_range;
    load         = (fire && in_range) ? sel_hot : '0;
  end

endmodule

// File: rtl/tsplit_slot.sv
module tsplit_slot
  import tsplit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              can_take,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  slot_state_e       state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;

  always_comb begin
    state_d = state_q;
    if (state_q == SLOT_FULL && out_ready) begin
      state_d = SLOT_EMPTY;
    end
    if (load) begin
      state_d = SLOT_FULL;
    end
    data_en  = load;
    can_take = (state_q == SLOT_EMPTY) || out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_EMPTY;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      data_q <= load_data;
    end
  end

  assign out_valid = (state_q == SLOT_FULL);
  assign out_data  = data_q;

endmodule

// File: rtl/token_split_node.sv
module token_split_node #(
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 4,
  parameter int CTRL_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      c_valid,
  output logic                      c_ready,
  input  logic [CTRL_W-1:0]         c_sel,
  input  logic                      a_valid,
  output logic                      a_ready,
  input  logic [DATA_W-1:0]         a_data,
  output logic [NUM_OUT-1:0]        z_valid,
  input  logic [NUM_OUT-1:0]        z_ready,
  output logic [NUM_OUT*DATA_W-1:0] z_data,
  output logic                      err_pulse
);

  logic               rst_core_n;
  logic               fire;
  logic               bad_sel;
  logic [NUM_OUT-1:0] load;
  logic [NUM_OUT-1:0] slot_ready;
  logic               err_q, err_d;

  tsplit_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  tsplit_steer #(.NUM_OUT(NUM_OUT), .CTRL_W(CTRL_W)) u_steer (
    .run        (rst_core_n),
    .c_valid    (c_valid),
    .a_valid    (a_valid),
    .c_sel      (c_sel),
    .slot_ready (slot_ready),
    .fire       (fire),
    .bad_sel    (bad_sel),
    .load       (load)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_slot
    tsplit_slot #(.DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .load      (load[i]),
      .load_data (a_data),
      .can_take  (slot_ready[i]),
      .out_valid (z_valid[i]),
      .out_ready (z_ready[i]),
      .out_data  (z_data[i*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    err_d = bad_sel;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign c_ready   = fire;
  assign a_ready   = fire;
  assign err_pulse = err_q;

endmodule

// File: rtl/tsplit_checker.sv
module tsplit_checker #(
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 4,
  parameter int CTRL_W  = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      c_valid,
  input logic                      c_ready,
  input logic [CTRL_W-1:0]         c_sel,
  input logic                      a_valid,
  input logic                      a_ready,
  input logic [DATA_W-1:0]         a_data,
  input logic [NUM_OUT-1:0]        z_valid,
  input logic [NUM_OUT-1:0]        z_ready,
  input logic [NUM_OUT*DATA_W-1:0] z_data,
  input logic                      err_pulse
);

  localparam logic [CTRL_W:0] SEL_LIMIT = (CTRL_W+1)'(NUM_OUT);

  logic              good_take;
  logic              bad_take;
  logic              prev_good;
  logic [CTRL_W-1:0] prev_sel;
  logic [DATA_W-1:0] prev_data;
  logic [NUM_OUT-1:0] held_prev;
  logic [NUM_OUT-1:0] fresh;
  logic              tgt_valid;
  logic [DATA_W-1:0] tgt_word;

  assign good_take = c_valid && c_ready && ({1'b0, c_sel} < SEL_LIMIT);
  assign bad_take  = c_valid && c_ready && !({1'b0, c_sel} < SEL_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_good <= 1'b0;
      prev_sel  <= '0;
      prev_data <= '0;
      held_prev <= '0;
    end else begin
      prev_good <= good_take;
      prev_sel  <= c_sel;
      prev_data <= a_data;
      held_prev <= z_valid & ~z_ready;
    end
  end

  assign fresh = z_valid & ~held_prev;

  always_comb begin
    tgt_valid = 1'b0;
    tgt_word  = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (prev_sel == CTRL_W'(i)) begin
        tgt_valid = z_valid[i];
        tgt_word  = z_data[i*DATA_W +: DATA_W];
      end
    end
  end

  a_r2_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    c_ready |-> (c_valid && a_valid));

  a_r5_joint_take: assert property (@(posedge clk) disable iff (!rst_n)
    c_ready == a_ready);

  a_r3_lands_on_target: assert property (@(posedge clk) disable iff (!rst_n)
    prev_good |-> (tgt_valid && tgt_word == prev_data));

  a_r4_single_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fresh) <= 1);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_good |-> (fresh == '0));

  a_r8_err_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
    bad_take |=> err_pulse);

  a_r8_err_only_bad: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_take |=> !err_pulse);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (z_valid[i] && !z_ready[i]) |=>
        (z_valid[i] && $stable(z_data[i*DATA_W +: DATA_W])));

    a_r6_target_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (z_valid[i] && !z_ready[i] && c_sel == CTRL_W'(i)) |-> !c_ready);
  end

endmodule

bind token_split_node tsplit_checker #(
  .DATA_W  (DATA_W),
  .NUM_OUT (NUM_OUT),
  .CTRL_W  (CTRL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .c_valid   (c_valid),
  .c_ready   (c_ready),
  .c_sel     (c_sel),
  .a_valid   (a_valid),
  .a_ready   (a_ready),
  .a_data    (a_data),
  .z_valid   (z_valid),
  .z_ready   (z_ready),
  .z_data    (z_data),
  .err_pulse (err_pulse)
);

// File: tb/tb_token_split_node.sv
module tb_token_split_node;

  localparam int DW = 8;
  localparam int NO = 4;
  localparam int CW = 3;

  logic            clk;
  logic            rst_n;
  logic            c_valid, c_ready, a_valid, a_ready, err_pulse;
  logic [CW-1:0]   c_sel;
  logic [DW-1:0]   a_data;
  logic [NO-1:0]   z_valid, z_ready;
  logic [NO*DW-1:0] z_data;

  int checks   = 0;
  int failures = 0;
  logic [DW-1:0] exp_q [NO][$];

  token_split_node #(.DATA_W(DW), .NUM_OUT(NO), .CTRL_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .c_valid(c_valid), .c_ready(c_ready), .c_sel(c_sel),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .z_valid(z_valid), .z_ready(z_ready), .z_data(z_data),
    .err_pulse(err_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // output monitor: a valid&ready seen at the falling edge transfers at the next rise
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NO; i++) begin
        if (z_valid[i] && z_ready[i]) begin
          if (exp_q[i].size() == 0) begin
            check(1'b0, "R4 unexpected token", i, -1);
          end else begin
            logic [DW-1:0] e;
            e = exp_q[i].pop_front();
            check(z_data[i*DW +: DW] == e, "R9 order/data", int'(z_data[i*DW +: DW]), int'(e));
          end
        end
      end
    end
  end

  // call just after a rising edge; returns just after the accepting edge
  task automatic send(input int sel, input logic [DW-1:0] d, output int waits);
    bit ok;
    c_valid = 1'b1; a_valid = 1'b1; c_sel = CW'(sel); a_data = d;
    waits = 0; ok = 1'b0;
    while (!ok) begin
      @(negedge clk);
      ok = c_ready;
      if (ok && sel < NO) exp_q[sel].push_back(d);
      if (!ok) waits++;
      @(posedge clk); #1;
    end
    c_valid = 1'b0; a_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(z_valid == '0, "R1 z_valid", int'(z_valid), 0);
    check(err_pulse == 1'b0, "R1 err_pulse", int'(err_pulse), 0);
    check(c_ready == 1'b0, "R1 c_ready", int'(c_ready), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_wait_both;
    c_valid = 1'b1; c_sel = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!c_ready && !a_ready, "R2 control alone", int'(c_ready), 0);
      @(posedge clk); #1;
    end
    c_valid = 1'b0; a_valid = 1'b1; a_data = 8'h11;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!c_ready && !a_ready, "R2 data alone", int'(a_ready), 0);
      @(posedge clk); #1;
    end
    a_valid = 1'b0;
    @(negedge clk);
    check(z_valid == '0, "R2 nothing emitted", int'(z_valid), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_route_each;
    int w;
    for (int i = 0; i < NO; i++) begin
      c_valid = 1'b1; a_valid = 1'b1; c_sel = CW'(i); a_data = DW'(8'h40 + i);
      @(negedge clk);
      check(c_ready == a_ready, "R5 joint ready", int'(a_ready), int'(c_ready));
      @(posedge clk); #1;
      if (c_ready === 1'bx) w = 0;
      c_valid = 1'b0; a_valid = 1'b0;
      exp_q[i].push_back(DW'(8'h40 + i));
      @(negedge clk);
      check(z_valid == NO'(1 << i), "R3/R4 one-hot target", int'(z_valid), 1 << i);
      check(z_data[i*DW +: DW] == DW'(8'h40 + i), "R3 payload", int'(z_data[i*DW +: DW]), 8'h40 + i);
      @(posedge clk); #1;
    end
  endtask

  task automatic t_bad_sel;
    int w;
    send(5, 8'hEE, w);
    check(w == 0, "R8 bad value consumed at once", w, 0);
    @(negedge clk);
    check(err_pulse == 1'b1, "R8 err raised", int'(err_pulse), 1);
    check(z_valid == '0, "R8 no output", int'(z_valid), 0);
    @(posedge clk); #1;
    @(negedge clk);
    check(err_pulse == 1'b0, "R8 err one cycle", int'(err_pulse), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_target_stall;
    int w;
    z_ready[2] = 1'b0;
    send(2, 8'hA1, w);
    c_valid = 1'b1; a_valid = 1'b1; c_sel = CW'(2); a_data = 8'hA2;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!c_ready && !a_ready, "R6 target stall blocks", int'(c_ready), 0);
      @(posedge clk); #1;
    end
    z_ready[2] = 1'b1;
    c_valid = 1'b0; a_valid = 1'b0;
    send(2, 8'hA2, w);
    check(w == 0, "R6 resumes when drained", w, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_side_stall;
    int w;
    int tot = 0;
    z_ready[0] = 1'b0;
    send(0, 8'hB0, w);
    for (int k = 0; k < 3; k++) begin
      send(1, DW'(8'hC0 + k), w);
      tot += w;
    end
    check(tot == 0, "R7 neighbour stall ignored", tot, 0);
    @(negedge clk);
    check(z_valid[0] == 1'b1, "R9 stalled token held", int'(z_valid[0]), 1);
    @(posedge clk); #1;
    z_ready[0] = 1'b1;
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic t_burst;
    int w;
    int tot = 0;
    for (int k = 0; k < 40; k++) begin
      send((k * 3 + k / 5) % NO, DW'(k * 7 + 3), w);
      tot += w;
    end
    check(tot == 0, "R10 one per cycle", tot, 0);
    repeat (3) @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int left;
    rst_n = 1'b0; c_valid = 1'b0; a_valid = 1'b0; c_sel = '0; a_data = '0;
    z_ready = '1;
    repeat (3) @(posedge clk); #1;
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    t_wait_both();
    t_route_each();
    t_bad_sel();
    t_target_stall();
    t_side_stall();
    t_burst();
    left = 0;
    for (int i = 0; i < NO; i++) left += exp_q[i].size();
    check(left == 0, "R9 all tokens delivered", left, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule